// File: doc/BRIEF.md
# Floppy Controller Recording-Mode and Lock Register File

This block keeps the settings that a floppy disk controller's command layer programs and that must outlive some resets but not others. One group selects the recording mode: a global pair of mode bits (GAP and WGATE), one perpendicular-mode bit per drive, and an overwrite enable that guards the per-drive bits. A second group holds the CONFIGURE parameters: FIFO enable, FIFO threshold and the track at which write precompensation starts. A LOCK bit decides whether a software reset may return that second group to its defaults.

The command decoder drives already-parsed strobes and fields into the block. The block answers with the effective recording mode of every drive, the GAP2 length, the number of GAP2 bytes that write data rewrites and the precompensation enable for a selected drive, the current CONFIGURE values, a status byte after each LOCK command, and a packed byte for the register dump. A synchronous active-high hardware reset clears everything; a one-cycle software reset pulse clears only part of it.

Top module: `fdc_mode_lock_regs`

## Requirements
- R1: A software reset pulse clears GAP and WGATE to 0.
- R2: A software reset pulse leaves the per-drive perpendicular bits unchanged.
- R3: A hardware reset clears GAP, WGATE, every per-drive bit and LOCK, and sets FIFO enable 0, threshold 0 and precompensation track 0; dump byte reads 0x00 and every drive reads conventional.
- R4: A mode write always loads GAP and WGATE; it loads the per-drive bits (drive 3..0 on perp_dbits[3:0]) only when perp_ow is 1.
- R5: While GAP or WGATE is 1 the per-drive bits are ignored and every drive takes the global mode.
- R6: Global mode WGATE=0,GAP=0 and WGATE=0,GAP=1 give conventional (GAP2 22, rewritten 0); WGATE=1,GAP=0 gives 500 kbps perpendicular (GAP2 22, rewritten 19); WGATE=1,GAP=1 gives 1 Mbps perpendicular (GAP2 41, rewritten 38).
- R7: With GAP=WGATE=0 a drive whose bit is 1 is perpendicular with GAP2 22 and 19 rewritten; a perpendicular drive has precomp_en 0 and a conventional drive has precomp_en 1.
- R8: With LOCK at 1, a software reset leaves FIFO enable, threshold and precompensation track unchanged.
- R9: With LOCK at 0, a software reset returns FIFO enable, threshold and precompensation track to 0.
- R10: One cycle after a LOCK command stat_vld is 1 for one cycle and stat_byte holds the new LOCK value at bit 4, all other bits 0.
- R11: dump_byte holds LOCK at bit 7, drive bits 3..0 at bits 5:2, GAP at bit 1, WGATE at bit 0, bit 6 zero.
- R12: Mode-derived outputs and dump_byte follow a command two clock edges after the edge that takes it; a software reset in the same cycle as a mode or configuration write wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| soft_rst | input | 1 | Software reset pulse |
| perp_wr | input | 1 | Mode command strobe |
| perp_ow | input | 1 | Overwrite enable for per-drive bits |
| perp_dbits | input | NUM_DRIVES | Per-drive perpendicular bits |
| perp_gap | input | 1 | GAP field of mode command |
| perp_wgate | input | 1 | WGATE field of mode command |
| cfg_wr | input | 1 | CONFIGURE command strobe |
| cfg_fifo_en | input | 1 | FIFO enable value |
| cfg_fifo_thr | input | THR_W | FIFO threshold value |
| cfg_pretrk | input | TRK_W | Precompensation start track value |
| lock_wr | input | 1 | LOCK command strobe |
| lock_val | input | 1 | LOCK value to store |
| drv_sel | input | SEL_W | Drive whose timing outputs are shown |
| drv_perp | output | NUM_DRIVES | Effective perpendicular flag per drive |
| gap2_len | output | 8 | GAP2 length in bytes, selected drive |
| gap2_rewr | output | 8 | GAP2 bytes rewritten by write data, selected drive |
| precomp_en | output | 1 | Write precompensation enable, selected drive |
| fifo_en | output | 1 | Effective FIFO enable |
| fifo_thr | output | THR_W | Effective FIFO threshold |
| pretrk | output | TRK_W | Effective precompensation start track |
| stat_vld | output | 1 | LOCK status byte valid |
| stat_byte | output | 8 | LOCK status byte |
| dump_byte | output | 8 | Register dump byte |

## Verification
A wrong mode register shows up at drv_perp, gap2_len, gap2_rewr and precomp_en two edges after the command, and a wrong reset subset shows on the same ports and on dump_byte two edges after the pulse, so each stimulus is followed by a check at that point. Lost or wrongly shielded CONFIGURE state shows directly on fifo_en, fifo_thr and pretrk one edge after the reset pulse. Stale overwrite handling only shows when a later write with the overwrite enable low is followed by selecting a drive whose bit would have changed, which the vector table arranges.

// File: rtl/fdc_mode_pkg.sv
package fdc_mode_pkg;
  typedef enum logic [1:0] {
    MD_CONV = 2'd0,
    MD_P500 = 2'd1,
    MD_P1M  = 2'd2
  } rec_mode_e;

  localparam logic [7:0] GAP2_STD  = 8'd22;
  localparam logic [7:0] GAP2_WIDE = 8'd41;
  localparam logic [7:0] REWR_P500 = 8'd19;
  localparam logic [7:0] REWR_P1M  = 8'd38;

  // Global bits dominate; the drive bit only counts when both are clear.
  function automatic rec_mode_e drive_mode(input logic gap, input logic wgate,
                                           input logic dbit);
    if (wgate)    return gap ? MD_P1M : MD_P500;
    else if (gap) return MD_CONV;
    else          return dbit ? MD_P500 : MD_CONV;
  endfunction

  function automatic logic [7:0] gap2_of(input rec_mode_e m);
    return (m == MD_P1M) ? GAP2_WIDE : GAP2_STD;
  endfunction

  function automatic logic [7:0] rewr_of(input rec_mode_e m);
    case (m)
      MD_P500: return REWR_P500;
      MD_P1M:  return REWR_P1M;
      default: return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/fdc_perp_regs.sv
module fdc_perp_regs #(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  soft_rst,
  input  logic                  wr,
  input  logic                  ow,
  input  logic [NUM_DRIVES-1:0] d_in,
  input  logic                  gap_in,
  input  logic                  wgate_in,
  output logic                  gap,
  output logic                  wgate,
  output logic [NUM_DRIVES-1:0] dbits
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gap   <= 1'b0;
      wgate <= 1'b0;
      dbits <= '0;
    end else if (soft_rst) begin
      gap   <= 1'b0;
      wgate <= 1'b0;
    end else if (wr) begin
      gap   <= gap_in;
      wgate <= wgate_in;
      if (ow) dbits <= d_in;
    end
  end

  AST_SOFT_CLR_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!gap && !wgate)); // R1
  AST_SOFT_KEEP_DRV: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> $stable(dbits)); // R2
  AST_NO_OW_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr && !ow) |=> $stable(dbits)); // R4
  AST_SOFT_WINS: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && wr && ow) |=> $stable(dbits)); // R12
endmodule

// File: rtl/fdc_cfg_lock.sv
module fdc_cfg_lock #(
  parameter int THR_W = 4,
  parameter int TRK_W = 8,
  parameter logic [THR_W-1:0] DEF_THR = '0,
  parameter logic [TRK_W-1:0] DEF_TRK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             cfg_wr,
  input  logic             cfg_fifo_en,
  input  logic [THR_W-1:0] cfg_fifo_thr,
  input  logic [TRK_W-1:0] cfg_pretrk,
  input  logic             lock_wr,
  input  logic             lock_val,
  output logic             lock_q,
  output logic             fifo_en,
  output logic [THR_W-1:0] fifo_thr,
  output logic [TRK_W-1:0] pretrk,
  output logic             stat_vld,
  output logic [7:0]       stat_byte
);
  localparam int LOCK_STAT_BIT = 4;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q    <= 1'b0;
      stat_vld  <= 1'b0;
      stat_byte <= 8'h00;
    end else begin
      stat_vld <= lock_wr;
      if (lock_wr) begin
        lock_q    <= lock_val;
        stat_byte <= 8'(lock_val) << LOCK_STAT_BIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en  <= 1'b0;
      fifo_thr <= DEF_THR;
      pretrk   <= DEF_TRK;
    end else if (soft_rst) begin
      if (!lock_q) begin
        fifo_en  <= 1'b0;
        fifo_thr <= DEF_THR;
        pretrk   <= DEF_TRK;
      end
    end else if (cfg_wr) begin
      fifo_en  <= cfg_fifo_en;
      fifo_thr <= cfg_fifo_thr;
      pretrk   <= cfg_pretrk;
    end
  end

  AST_LOCK_SHIELD: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && lock_q) |=> $stable({fifo_en, fifo_thr, pretrk})); // R8
  AST_UNLOCK_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !lock_q) |=> (!fifo_en && fifo_thr == DEF_THR && pretrk == DEF_TRK)); // R9
  AST_STAT_ECHO: assert property (@(posedge clk) disable iff (rst)
    lock_wr |=> (stat_vld && stat_byte[LOCK_STAT_BIT] == lock_q &&
                 $countones(stat_byte) <= 1)); // R10
endmodule

// File: rtl/fdc_drive_mode.sv
module fdc_drive_mode
  import fdc_mode_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  gap,
  input  logic                  wgate,
  input  logic [NUM_DRIVES-1:0] dbits,
  input  logic [SEL_W-1:0]      drv_sel,
  output logic [NUM_DRIVES-1:0] drv_perp,
  output logic [7:0]            gap2_len,
  output logic [7:0]            gap2_rewr,
  output logic                  precomp_en
);
  rec_mode_e                 mode_w [NUM_DRIVES];
  logic [NUM_DRIVES-1:0]     perp_w;
  rec_mode_e                 sel_mode;

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    assign mode_w[d] = drive_mode(gap, wgate, dbits[d]);
    assign perp_w[d] = (mode_w[d] != MD_CONV);
  end

  assign sel_mode = mode_w[drv_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_perp   <= '0;
      gap2_len   <= GAP2_STD;
      gap2_rewr  <= 8'd0;
      precomp_en <= 1'b1;
    end else begin
      drv_perp   <= perp_w;
      gap2_len   <= gap2_of(sel_mode);
      gap2_rewr  <= rewr_of(sel_mode);
      precomp_en <= (sel_mode == MD_CONV);
    end
  end

  AST_GLOBAL_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    (gap || wgate) |=> (drv_perp == '0 || drv_perp == '1)); // R5
  AST_PRECOMP_CONV: assert property (@(posedge clk) disable iff (rst)
    precomp_en |-> (gap2_rewr == 8'd0 && gap2_len == GAP2_STD)); // R7
  AST_WIDE_GAP: assert property (@(posedge clk) disable iff (rst)
    (gap2_len == GAP2_WIDE) |-> (gap2_rewr == REWR_P1M && !precomp_en)); // R6
endmodule

// File: rtl/fdc_mode_lock_regs.sv
module fdc_mode_lock_regs #(
  parameter  int NUM_DRIVES = 4,
  parameter  int THR_W = 4,
  parameter  int TRK_W = 8,
  localparam int SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  soft_rst,
  input  logic                  perp_wr,
  input  logic                  perp_ow,
  input  logic [NUM_DRIVES-1:0] perp_dbits,
  input  logic                  perp_gap,
  input  logic                  perp_wgate,
  input  logic                  cfg_wr,
  input  logic                  cfg_fifo_en,
  input  logic [THR_W-1:0]      cfg_fifo_thr,
  input  logic [TRK_W-1:0]      cfg_pretrk,
  input  logic                  lock_wr,
  input  logic                  lock_val,
  input  logic [SEL_W-1:0]      drv_sel,
  output logic [NUM_DRIVES-1:0] drv_perp,
  output logic [7:0]            gap2_len,
  output logic [7:0]            gap2_rewr,
  output logic                  precomp_en,
  output logic                  fifo_en,
  output logic [THR_W-1:0]      fifo_thr,
  output logic [TRK_W-1:0]      pretrk,
  output logic                  stat_vld,
  output logic [7:0]            stat_byte,
  output logic [7:0]            dump_byte
);
  localparam int DUMP_LOCK = 7;
  localparam int DUMP_DRV  = 2;

  logic                  gap_q, wgate_q, lock_q;
  logic [NUM_DRIVES-1:0] dbits_q;
  logic [7:0]            dump_w;

  fdc_perp_regs #(.NUM_DRIVES(NUM_DRIVES)) u_perp (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr(perp_wr), .ow(perp_ow),
    .d_in(perp_dbits), .gap_in(perp_gap), .wgate_in(perp_wgate),
    .gap(gap_q), .wgate(wgate_q), .dbits(dbits_q)
  );

  fdc_cfg_lock #(.THR_W(THR_W), .TRK_W(TRK_W)) u_cfg (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
    .cfg_fifo_en(cfg_fifo_en), .cfg_fifo_thr(cfg_fifo_thr), .cfg_pretrk(cfg_pretrk),
    .lock_wr(lock_wr), .lock_val(lock_val), .lock_q(lock_q),
    .fifo_en(fifo_en), .fifo_thr(fifo_thr), .pretrk(pretrk),
    .stat_vld(stat_vld), .stat_byte(stat_byte)
  );

  fdc_drive_mode #(.NUM_DRIVES(NUM_DRIVES), .SEL_W(SEL_W)) u_drv (
    .clk(clk), .rst(rst), .gap(gap_q), .wgate(wgate_q), .dbits(dbits_q),
    .drv_sel(drv_sel), .drv_perp(drv_perp), .gap2_len(gap2_len),
    .gap2_rewr(gap2_rewr), .precomp_en(precomp_en)
  );

  always_comb begin
    dump_w                         = 8'h00;
    dump_w[DUMP_LOCK]              = lock_q;
    dump_w[DUMP_DRV +: NUM_DRIVES] = dbits_q;
    dump_w[1]                      = gap_q;
    dump_w[0]                      = wgate_q;
  end

  always_ff @(posedge clk) begin
    if (rst) dump_byte <= 8'h00;
    else     dump_byte <= dump_w;
  end

  AST_HW_CLEAR: assert property (@(posedge clk)
    rst |=> (!lock_q && dbits_q == '0 && !gap_q && !wgate_q && !fifo_en &&
             fifo_thr == '0 && pretrk == '0)); // R3
  AST_DUMP_SPARE: assert property (@(posedge clk) disable iff (rst)
    !dump_byte[6]); // R11
endmodule

// File: tb/fdc_mode_lock_regs_tb.sv
`timescale 1ns/1ps
module fdc_mode_lock_regs_tb;
  logic       clk = 1'b0;
  logic       rst, soft_rst, perp_wr, perp_ow, perp_gap, perp_wgate;
  logic [3:0] perp_dbits;
  logic       cfg_wr, cfg_fifo_en, lock_wr, lock_val;
  logic [3:0] cfg_fifo_thr;
  logic [7:0] cfg_pretrk;
  logic [1:0] drv_sel;
  logic [3:0] drv_perp;
  logic [7:0] gap2_len, gap2_rewr, stat_byte, dump_byte, pretrk;
  logic       precomp_en, fifo_en, stat_vld;
  logic [3:0] fifo_thr;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fdc_mode_lock_regs u_dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .perp_wr(perp_wr), .perp_ow(perp_ow),
    .perp_dbits(perp_dbits), .perp_gap(perp_gap), .perp_wgate(perp_wgate),
    .cfg_wr(cfg_wr), .cfg_fifo_en(cfg_fifo_en), .cfg_fifo_thr(cfg_fifo_thr),
    .cfg_pretrk(cfg_pretrk), .lock_wr(lock_wr), .lock_val(lock_val), .drv_sel(drv_sel),
    .drv_perp(drv_perp), .gap2_len(gap2_len), .gap2_rewr(gap2_rewr),
    .precomp_en(precomp_en), .fifo_en(fifo_en), .fifo_thr(fifo_thr), .pretrk(pretrk),
    .stat_vld(stat_vld), .stat_byte(stat_byte), .dump_byte(dump_byte)
  );

  // {mode byte, drive, exp precomp, exp gap2, exp rewritten}
  // mode byte: [7] overwrite, [5:2] drive bits 3..0, [1] GAP, [0] WGATE
  localparam logic [31:0] VEC [12] = '{
    32'h00011600, 32'h01201613, 32'h03102926, 32'h02311600,
    32'h84001613, 32'h84111600, 32'h20311600, 32'h00001613,
    32'h02011600, 32'h03302926, 32'hBC201613, 32'h80211600
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    soft_rst = 0; perp_wr = 0; cfg_wr = 0; lock_wr = 0;
  endtask

  task automatic set_mode(input logic [7:0] b);
    perp_ow = b[7]; perp_dbits = b[5:2]; perp_gap = b[1]; perp_wgate = b[0];
  endtask

  // pulse the prepared strobes for one edge, then wait for the second edge
  task automatic fire();
    @(negedge clk); idle();
    @(negedge clk);
  endtask

  task automatic do_mode(input logic [7:0] b);
    set_mode(b); perp_wr = 1; fire();
  endtask

  task automatic do_cfg(input logic en, input logic [3:0] thr, input logic [7:0] trk);
    cfg_fifo_en = en; cfg_fifo_thr = thr; cfg_pretrk = trk; cfg_wr = 1; fire();
  endtask

  task automatic do_soft();
    soft_rst = 1; fire();
  endtask

  task automatic do_hw();
    rst = 1; @(negedge clk); @(negedge clk); rst = 0; @(negedge clk);
  endtask

  initial begin
    rst = 1; idle(); set_mode(8'h00); drv_sel = 0;
    cfg_fifo_en = 0; cfg_fifo_thr = 0; cfg_pretrk = 0; lock_val = 0;
    @(negedge clk); @(negedge clk); rst = 0;
    @(negedge clk);
    check("R3 reset drv_perp", 32'(drv_perp), 0);
    check("R3 reset cfg", {fifo_en, fifo_thr, pretrk}, 0);
    check("R3 reset dump", 32'(dump_byte), 0);
    check("R3 reset precomp/gap2", {precomp_en, gap2_len, gap2_rewr}, {1'b1, 8'd22, 8'd0});

    for (int i = 0; i < 12; i++) begin
      drv_sel = VEC[i][21:20];
      do_mode(VEC[i][31:24]);
      check($sformatf("R4/R5/R6/R7 vec%0d", i), {precomp_en, gap2_len, gap2_rewr},
            {VEC[i][16], VEC[i][15:8], VEC[i][7:0]});
    end

    // R12 latency: conventional -> global 500k takes two edges
    do_mode(8'h80); drv_sel = 0;
    set_mode(8'h01); perp_wr = 1;
    @(negedge clk); idle();
    check("R12 one edge unchanged", 32'(drv_perp), 0);
    @(negedge clk);
    check("R12 two edges updated", 32'(drv_perp), 32'hF);

    // R11 dump layout, R5 override view
    do_mode(8'h97);
    check("R11 dump", 32'(dump_byte), 32'h17);
    check("R5 all drives global", 32'(drv_perp), 32'hF);
    do_soft();
    check("R1 soft clears global", 32'(dump_byte[1:0]), 0);
    check("R2 soft keeps drive bits", 32'(drv_perp), 32'h5);
    check("R2 dump after soft", 32'(dump_byte), 32'h14);

    // R9 unlocked soft reset restores defaults
    do_cfg(1, 4'd5, 8'h40);
    check("R9 cfg loaded", {fifo_en, fifo_thr, pretrk}, {1'b1, 4'd5, 8'h40});
    do_soft();
    check("R9 unlocked defaults", {fifo_en, fifo_thr, pretrk}, 0);

    // R10 status byte
    lock_val = 1; lock_wr = 1;
    @(negedge clk); idle();
    check("R10 stat lock=1", {stat_vld, stat_byte}, {1'b1, 8'h10});
    @(negedge clk);
    check("R10 stat_vld one cycle", 32'(stat_vld), 0);
    check("R11 dump lock bit", 32'(dump_byte), 32'h94);

    // R8 locked soft reset keeps config
    do_cfg(1, 4'd9, 8'h7E);
    do_soft();
    check("R8 locked keeps cfg", {fifo_en, fifo_thr, pretrk}, {1'b1, 4'd9, 8'h7E});

    lock_val = 0; lock_wr = 1;
    @(negedge clk); idle();
    check("R10 stat lock=0", {stat_vld, stat_byte}, {1'b1, 8'h00});
    lock_val = 1; lock_wr = 1; fire();

    // R3 hardware reset overrides lock
    do_hw();
    check("R3 hw clears lock/cfg", {fifo_en, fifo_thr, pretrk}, 0);
    @(negedge clk);
    check("R3 hw dump", 32'(dump_byte), 0);
    check("R3 hw drives", 32'(drv_perp), 0);

    // R12 soft reset wins against same-cycle writes
    do_mode(8'h84);
    do_cfg(1, 4'd3, 8'h11);
    set_mode(8'hBB); perp_wr = 1;
    cfg_fifo_en = 1; cfg_fifo_thr = 4'd7; cfg_pretrk = 8'h22; cfg_wr = 1;
    do_soft();
    check("R12 soft beats mode write", 32'(drv_perp), 32'h1);
    check("R12 soft beats cfg write", {fifo_en, fifo_thr, pretrk}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule